// File: doc/BRIEF.md
# Three-Level Vectored Interrupt Controller

This block arbitrates interrupt requests from 21 level-sensitive source flags that are grouped onto 10 vectors. Each vector has one priority bit. Cleared, the vector sits at the low level. Set, it sits at a raised level, and that level depends on the vector. The first two vectors rise to the highest level. All the others rise to the middle level. The block finds the winning vector in combinational logic. It raises `irq_o` when the winner's level is strictly above the level now in service. On a CPU acknowledge it captures the winner's address and pushes the winner's level onto a small in-service stack.

A return-from-interrupt pops the stack and restores the previous threshold. This allows nested service in which only a strictly higher level may interrupt a handler that is running. Per-source enable bits and per-vector level bits are held in configuration registers that load in whole words. Source edge detection and the CPU are outside the block.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `irq_o` is 0, `vec_addr_o` is 0 and `cur_lvl_o` is 0 (stack empty). All source enables are cleared and every vector is at the low level, so pending flags alone raise no request.
- R2: Vector n (n = 1..10) has the address 0x03 + 8·(n−1). The address appears on `vec_addr_o` in the cycle after an accepted acknowledge and holds until the next accepted one.
- R3: Bit n−1 of the level word selects the level of vector n. A value of 0 means low. A value of 1 means highest for vectors 1 and 2 and middle for vectors 3..10. `cur_lvl_o` encodes 0 = none, 1 = low, 2 = middle, 3 = highest.
- R4: When pending vectors have different levels, the one with the highest level wins.
- R5: Among pending vectors of equal level, the lowest vector number wins.
- R6: Sources are numbered in consecutive groups: vector 1 takes source 0, vector 2 takes 1, vector 3 takes 2..4, vector 4 takes 5..7, vector 5 takes 8, vector 6 takes 9..10, vector 7 takes 11, vector 8 takes 12, vector 9 takes 13..15 and vector 10 takes 16..20. A vector is pending when any of its enabled sources is flagged.
- R7: A flagged source whose enable bit is 0 takes no part in arbitration.
- R8: `irq_o` is 1 only when the winning level is strictly above `cur_lvl_o`. A request at or below the level in service is refused.
- R9: An acknowledge while `irq_o` is 1 pushes the winner's level, which shows on `cur_lvl_o` in the next cycle. An acknowledge while `irq_o` is 0 changes nothing.
- R10: A return pops one level. A return with an empty stack changes nothing. When return and acknowledge arrive together, the return is performed and the acknowledge is dropped.
- R11: A write strobe loads the whole enable word or level word. The new value takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 21 | Pending flag per source |
| cfg_en_we | input | 1 | Load strobe for the enable word |
| cfg_en_data | input | 21 | New enable word, one bit per source |
| cfg_lvl_we | input | 1 | Load strobe for the level word |
| cfg_lvl_data | input | 10 | New level word, one bit per vector |
| ack_i | input | 1 | CPU acknowledge of the current request |
| reti_i | input | 1 | Return from the handler now running |
| irq_o | output | 1 | Request to the CPU |
| vec_addr_o | output | 8 | Address of the last acknowledged vector |
| cur_lvl_o | output | 2 | Level at the top of the in-service stack |

## Verification
The bench builds the block with its default parameters: ten vectors, two of them able to reach the highest level, a three-entry stack and 8-bit addresses. These settings make every level reachable. They allow a full nest of middle under highest, plus the boundary moves on the stack: a return on an empty stack and an acknowledge that arrives together with a return. With these values the bench also reaches the five-source group at the last vector, which sits at the top address 0x4B.

// File: rtl/ivc_pkg.sv
// Shared types and source-to-vector mapping for the interrupt controller.
// Assumes the source grouping below; vectors beyond the table own one source.
package ivc_pkg;

    typedef logic [1:0] lvl_t;

    localparam lvl_t LVL_NONE = 2'd0;
    localparam lvl_t LVL_LOW  = 2'd1;
    localparam lvl_t LVL_MID  = 2'd2;
    localparam lvl_t LVL_TOP  = 2'd3;

    // Number of sources feeding vector v (zero based).
    function automatic int src_count(input int v);
        case (v)
            2, 3, 8: return 3;
            5:       return 2;
            9:       return 5;
            default: return 1;
        endcase
    endfunction

    // Index of the first source of vector v.
    function automatic int first_src(input int v);
        int acc;
        acc = 0;
        for (int i = 0; i < v; i++) acc += src_count(i);
        return acc;
    endfunction

    // Vector that source s belongs to, searched over nvec vectors.
    function automatic int vec_of_src(input int s, input int nvec);
        int hit;
        hit = 0;
        for (int v = 0; v < nvec; v++)
            if (s >= first_src(v) && s < first_src(v) + src_count(v)) hit = v;
        return hit;
    endfunction

endpackage

// File: rtl/ivc_cfg_regs.sv
// Configuration registers: per-source enable word and per-vector level word.
// Assumes whole-word writes; reset clears enables and sets every vector low.
module ivc_cfg_regs #(
    parameter int NUM_SRC = 21,
    parameter int NUM_VEC = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_we,
    input  logic [NUM_SRC-1:0] en_data,
    input  logic               lvl_we,
    input  logic [NUM_VEC-1:0] lvl_data,
    output logic [NUM_SRC-1:0] en_q,
    output logic [NUM_VEC-1:0] lvl_hi_q
);

    // Enable word register.
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (en_we) en_q <= en_data;
    end

    // Level word register.
    always_ff @(posedge clk) begin
        if (!rst_n)      lvl_hi_q <= '0;
        else if (lvl_we) lvl_hi_q <= lvl_data;
    end

    // R11
    // en_load_chk
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_we |=> en_q == $past(en_data));

endmodule

// File: rtl/ivc_src_merge.sv
// Folds enabled source flags onto their vectors (OR over each group).
// Assumes level-sensitive flags that are already synchronous to clk.
module ivc_src_merge
    import ivc_pkg::*;
#(
    parameter int NUM_SRC = 21,
    parameter int NUM_VEC = 10
) (
    input  logic [NUM_SRC-1:0] req_i,
    input  logic [NUM_SRC-1:0] en_i,
    output logic [NUM_VEC-1:0] pend_o
);

    // OR every enabled, flagged source into its vector.
    always_comb begin
        pend_o = '0;
        for (int s = 0; s < NUM_SRC; s++)
            if (req_i[s] && en_i[s]) pend_o[vec_of_src(s, NUM_VEC)] = 1'b1;
    end

endmodule

// File: rtl/ivc_arbiter.sv
// Picks the pending vector with the highest level; ties go to the lowest index.
// Assumes vectors below X_VECS rise to the top level, others to the middle.
module ivc_arbiter
    import ivc_pkg::*;
#(
    parameter int NUM_VEC = 10,
    parameter int X_VECS  = 2,
    localparam int VIDX_W = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] pend_i,
    input  logic [NUM_VEC-1:0] lvl_hi_i,
    output logic               win_valid_o,
    output logic [VIDX_W-1:0]  win_idx_o,
    output lvl_t               win_lvl_o
);

    lvl_t rank [NUM_VEC];

    // Effective level of each vector, or none when it is idle.
    for (genvar v = 0; v < NUM_VEC; v++) begin : g_rank
        if (v < X_VECS) begin : g_top
            assign rank[v] = !pend_i[v] ? LVL_NONE : (lvl_hi_i[v] ? LVL_TOP : LVL_LOW);
        end else begin : g_mid
            assign rank[v] = !pend_i[v] ? LVL_NONE : (lvl_hi_i[v] ? LVL_MID : LVL_LOW);
        end
    end

    // Scan upward; only a strictly higher level replaces the holder.
    always_comb begin
        win_lvl_o = LVL_NONE;
        win_idx_o = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            if (rank[v] > win_lvl_o) begin
                win_lvl_o = rank[v];
                win_idx_o = VIDX_W'(v);
            end
        end
    end

    assign win_valid_o = (win_lvl_o != LVL_NONE);

    // R5
    // win_pending_chk
    win_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid_o |-> pend_i[win_idx_o]);

    // R7
    // idle_no_win_chk
    idle_no_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_i == '0) |-> !win_valid_o);

endmodule

// File: rtl/ivc_level_stack.sv
// Stack of in-service levels; the top is the refusal threshold.
// Assumes the caller never asserts push and pop together.
module ivc_level_stack
    import ivc_pkg::*;
#(
    parameter int DEPTH = 3,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  lvl_t push_lvl_i,
    input  logic pop_i,
    output lvl_t top_o
);

    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    lvl_t             stk_q [DEPTH];
    logic [CNT_W-1:0] cnt_q;

    // Occupancy counter: pop when non-empty, push when not full.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (pop_i && cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
        else if (push_i && !pop_i && cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
    end

    // Entry storage: a push writes the slot just above the current top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) stk_q[i] <= LVL_NONE;
        end else if (push_i && !pop_i) begin
            for (int i = 0; i < DEPTH; i++)
                if (cnt_q == CNT_W'(i)) stk_q[i] <= push_lvl_i;
        end
    end

    // Top-of-stack select, none when empty.
    always_comb begin
        top_o = LVL_NONE;
        for (int i = 0; i < DEPTH; i++)
            if (cnt_q == CNT_W'(i + 1)) top_o = stk_q[i];
    end

    // R10
    // empty_pop_chk
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && cnt_q == '0) |=> cnt_q == '0);

    // R9
    // push_top_chk
    push_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && cnt_q != FULL) |=> top_o == $past(push_lvl_i));

endmodule

// File: rtl/irq_vector_ctrl.sv
// Three-level vectored interrupt controller top: config, merge, arbiter, stack.
// Assumes one acknowledge per request and returns matched to acknowledges.
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int NUM_VEC   = 10,
    parameter int X_VECS    = 2,
    parameter int DEPTH     = 3,
    parameter int ADDR_W    = 8,
    parameter int ADDR_BASE = 3,
    parameter int ADDR_STEP = 8,
    localparam int NUM_SRC  = first_src(NUM_VEC),
    localparam int VIDX_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               cfg_en_we,
    input  logic [NUM_SRC-1:0] cfg_en_data,
    input  logic               cfg_lvl_we,
    input  logic [NUM_VEC-1:0] cfg_lvl_data,
    input  logic               ack_i,
    input  logic               reti_i,
    output logic               irq_o,
    output logic [ADDR_W-1:0]  vec_addr_o,
    output logic [1:0]         cur_lvl_o
);

    logic [NUM_SRC-1:0] en_q;
    logic [NUM_VEC-1:0] lvl_hi_q;
    logic [NUM_VEC-1:0] pend;
    logic               win_valid;
    logic [VIDX_W-1:0]  win_idx;
    lvl_t               win_lvl;
    lvl_t               thresh;
    logic               take;

    ivc_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_we    (cfg_en_we),
        .en_data  (cfg_en_data),
        .lvl_we   (cfg_lvl_we),
        .lvl_data (cfg_lvl_data),
        .en_q     (en_q),
        .lvl_hi_q (lvl_hi_q)
    );

    ivc_src_merge #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC)) u_merge (
        .req_i  (req_i),
        .en_i   (en_q),
        .pend_o (pend)
    );

    ivc_arbiter #(.NUM_VEC(NUM_VEC), .X_VECS(X_VECS)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend_i      (pend),
        .lvl_hi_i    (lvl_hi_q),
        .win_valid_o (win_valid),
        .win_idx_o   (win_idx),
        .win_lvl_o   (win_lvl)
    );

    ivc_level_stack #(.DEPTH(DEPTH)) u_stack (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (take),
        .push_lvl_i (win_lvl),
        .pop_i      (reti_i),
        .top_o      (thresh)
    );

    // Request only when the winner is strictly above the level in service.
    assign irq_o     = win_valid && (win_lvl > thresh);
    // An acknowledge counts only with a live request and no return.
    assign take      = ack_i && irq_o && !reti_i;
    assign cur_lvl_o = thresh;

    // Capture the winner's address on an accepted acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    vec_addr_o <= '0;
        else if (take) vec_addr_o <= ADDR_W'(ADDR_BASE + ADDR_STEP * int'(win_idx));
    end

    // R8
    // nest_rise_chk
    nest_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> cur_lvl_o > $past(cur_lvl_o));

    // R2
    // addr_hold_chk
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(vec_addr_o));

    // R7
    // masked_quiet_chk
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_i & en_q) == '0) |-> !irq_o);

endmodule

// File: tb/test_irq_vector_ctrl.sv
// Scoreboard bench: driver tasks queue the expected outputs for each cycle,
// a negedge monitor pops and compares them.
module test_irq_vector_ctrl;

    localparam int NS = 21;
    localparam int NV = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] req = '0;
    logic          cfg_en_we = 1'b0;
    logic [NS-1:0] cfg_en_data = '0;
    logic          cfg_lvl_we = 1'b0;
    logic [NV-1:0] cfg_lvl_data = '0;
    logic          ack = 1'b0;
    logic          reti = 1'b0;
    logic          irq;
    logic [7:0]    vaddr;
    logic [1:0]    clvl;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct {
        logic       irq;
        logic [7:0] addr;
        logic [1:0] lvl;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    irq_vector_ctrl i_irq_vector_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .cfg_en_we    (cfg_en_we),
        .cfg_en_data  (cfg_en_data),
        .cfg_lvl_we   (cfg_lvl_we),
        .cfg_lvl_data (cfg_lvl_data),
        .ack_i        (ack),
        .reti_i       (reti),
        .irq_o        (irq),
        .vec_addr_o   (vaddr),
        .cur_lvl_o    (clvl)
    );

    function automatic logic [7:0] addr_of(input int n);
        return 8'(3 + 8 * (n - 1));
    endfunction

    // Monitor: compare outputs with the queued expectation at each negedge.
    always @(negedge clk) begin
        exp_t it;
        if (sb_q.size() > 0) begin
            it = sb_q.pop_front();
            n_chk++;
            if (irq !== it.irq || vaddr !== it.addr || clvl !== it.lvl) begin
                n_err++;
                $display("FAIL %s: actual irq=%0b addr=%02h lvl=%0d expected irq=%0b addr=%02h lvl=%0d",
                         it.tag, irq, vaddr, clvl, it.irq, it.addr, it.lvl);
            end
        end
    end

    // Driver: set strobes for one cycle and queue what that cycle must show.
    task automatic cyc(input logic a, input logic r, input logic e_irq,
                       input logic [7:0] e_addr, input logic [1:0] e_lvl, input string tag);
        exp_t it;
        ack = a;
        reti = r;
        it.irq = e_irq; it.addr = e_addr; it.lvl = e_lvl; it.tag = tag;
        sb_q.push_back(it);
        @(posedge clk);
        #1;
        ack = 1'b0;
        reti = 1'b0;
        cfg_en_we = 1'b0;
        cfg_lvl_we = 1'b0;
    endtask

    task automatic wr_cfg(input logic [NS-1:0] en, input logic [NV-1:0] lv, input logic e_irq,
                          input logic [7:0] e_addr, input logic [1:0] e_lvl, input string tag);
        cfg_en_data = en;
        cfg_lvl_data = lv;
        cfg_en_we = 1'b1;
        cfg_lvl_we = 1'b1;
        cyc(1'b0, 1'b0, e_irq, e_addr, e_lvl, tag);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        req = '1;
        cyc(0, 0, 0, 8'h00, 0, "R1 reset state, flags set but nothing enabled");
        wr_cfg(NS'(1) << 12, '0, 0, 8'h00, 0, "R11 enable write not yet visible");
        cyc(0, 0, 1, 8'h00, 0, "R6 R11 vector 8 source now requests");
        cyc(1, 0, 1, 8'h00, 0, "R9 acknowledge cycle");
        cyc(0, 0, 0, addr_of(8), 1, "R2 R8 vector 8 address, low level refused");
        cyc(0, 1, 0, addr_of(8), 1, "R10 return cycle");
        cyc(0, 0, 1, addr_of(8), 0, "R10 stack popped to empty");
        // Equal levels.
        wr_cfg((NS'(1) << 12) | (NS'(1) << 3), '0, 1, addr_of(8), 0, "R11 tie setup");
        cyc(1, 0, 1, addr_of(8), 0, "R5 acknowledge with tie");
        cyc(0, 1, 0, addr_of(3), 1, "R5 lowest vector wins tie");
        cyc(0, 0, 1, addr_of(3), 0, "R10 popped");
        // Different levels and nesting.
        wr_cfg((NS'(1) << 12) | (NS'(1) << 3) | NS'(1), NV'(1) << 7, 1, addr_of(3), 0, "R11 level setup");
        cyc(1, 0, 1, addr_of(3), 0, "R4 acknowledge mixed levels");
        cyc(0, 0, 0, addr_of(8), 2, "R4 R3 middle vector 8 beats low ones");
        wr_cfg((NS'(1) << 12) | (NS'(1) << 3) | NS'(1), (NV'(1) << 7) | NV'(1), 0, addr_of(8), 2, "R8 low refused under middle");
        cyc(1, 0, 1, addr_of(8), 2, "R8 highest nests over middle");
        cyc(1, 0, 0, addr_of(1), 3, "R3 vector 1 raised is highest");
        cyc(0, 0, 0, addr_of(1), 3, "R9 acknowledge without request ignored");
        cyc(0, 1, 0, addr_of(1), 3, "R10 return from highest");
        cyc(0, 0, 1, addr_of(1), 2, "R10 back to middle");
        cyc(0, 1, 1, addr_of(1), 2, "R10 return from middle");
        cyc(0, 0, 1, addr_of(1), 0, "R10 stack empty");
        cyc(0, 1, 1, addr_of(1), 0, "R10 return on empty stack");
        cyc(0, 0, 1, addr_of(1), 0, "R10 empty return ignored");
        // Acknowledge together with return.
        wr_cfg((NS'(1) << 12) | (NS'(1) << 3) | NS'(1), NV'(1) << 7, 1, addr_of(1), 0, "R11 drop vector 1 to low");
        cyc(1, 0, 1, addr_of(1), 0, "R9 acknowledge middle");
        cyc(0, 0, 0, addr_of(8), 2, "R9 middle in service");
        wr_cfg((NS'(1) << 12) | (NS'(1) << 3) | NS'(1), (NV'(1) << 7) | NV'(1), 0, addr_of(8), 2, "R11 raise vector 1");
        cyc(1, 1, 1, addr_of(8), 2, "R10 acknowledge with return");
        cyc(0, 0, 1, addr_of(8), 0, "R10 return wins, acknowledge dropped");
        // Shared vector.
        req = NS'(1) << 19;
        wr_cfg(NS'(1) << 19, '0, 0, addr_of(8), 0, "R7 flags of disabled sources only");
        cyc(1, 0, 1, addr_of(8), 0, "R6 acknowledge vector 10 member");
        cyc(0, 1, 0, addr_of(10), 1, "R6 vector 10 address");
        cyc(0, 0, 1, addr_of(10), 0, "R10 popped");
        // Disabled member of a group.
        req = (NS'(1) << 9) | (NS'(1) << 19);
        wr_cfg(NS'(1) << 10, '0, 1, addr_of(10), 0, "R11 old enable still active");
        cyc(1, 0, 0, addr_of(10), 0, "R7 flagged but disabled source ignored");
        cyc(0, 0, 0, addr_of(10), 0, "R7 R9 address and stack untouched");
        // Raised level on a middle-capable vector.
        req = NS'(1) << 2;
        wr_cfg(NS'(1) << 2, NV'(1) << 2, 0, addr_of(10), 0, "R11 setup vector 3");
        cyc(1, 0, 1, addr_of(10), 0, "R3 acknowledge vector 3");
        cyc(0, 0, 0, addr_of(3), 2, "R3 vector 3 raised is middle");
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule